// File: doc/BRIEF.md
# SPI Flash Identification Read Responder

This block is the device-side front end of a serial flash slave that answers only the standard manufacturer and device identification query. A host selects the slave by pulling chip select low and clocks one command byte in on the serial data input. If that byte is the identification command, the block drives a fixed identification stream back on the serial data output for as long as the host keeps clocking and holds chip select low. Any other command leaves the output released for the whole frame.

All three host pins are brought into the local clock domain through synchronizer chains. Clock edges are then found by comparing successive synchronized samples. Input bits are taken on rising clock edges. Output bits change on falling clock edges, so the same logic serves hosts that idle the clock low and hosts that idle it high. Releasing chip select ends the frame at any bit and releases the output.

Top module: `spi_id_responder`

## Requirements
- R1: While reset is held, and right after it is released with chip select high, the output enable `sdo_oe` is 0 and `sdo` is 0.
- R2: The command byte is taken MSB first, one bit per rising edge of `sck`. Command value 0x9F selects the identification response. `sdo_oe` stays 0 until the first falling edge of `sck` that follows the eighth rising edge.
- R3: `sdo` changes only after a falling edge of `sck`, or when the frame ends. It holds its value while `sck` is high.
- R4: After command 0x9F, the stream is four bytes sent MSB first: 0x1F, then 0x28, then the parameter `DEV_ID_TAIL`, then the length byte 0x00.
- R5: After the fourth byte, `sdo` stays 0 with `sdo_oe` at 1 for every further bit, until chip select rises.
- R6: For any command value other than 0x9F, `sdo_oe` stays 0 for the rest of the frame, whatever is clocked afterwards.
- R7: While `cs_n` is high, `sdo_oe` is 0. Clock and data activity while deselected has no effect: a following frame still answers 0x9F from its first byte.
- R8: Raising `cs_n` in the middle of a byte drops `sdo_oe` within a few local clock cycles. The next frame restarts the stream at 0x1F.
- R9: The identification stream is the same when `sck` idles low (mode 0) and when it idles high (mode 3).
- R10: A frame starts only on a high-to-low transition of `cs_n`. If `cs_n` is already low when reset is released, the block ignores traffic until `cs_n` has gone high and then low again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock used to oversample the host pins |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select from the host, active low |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver; 0 means high impedance |

## Verification
The assertions assume that each high or low phase of `sck` lasts several local clock cycles, at least the synchronizer depth plus two. They also assume that `sdi` and `cs_n` do not change in the same local cycle as an `sck` edge. Under these assumptions every host edge appears as one clean single-cycle event after synchronization. The stimulus holds each `sck` phase for eight local cycles and changes `sdi` only at the start of the low phase. It moves `cs_n` at least half an `sck` period away from any clock edge, both when the clock idles low and when it idles high.

// File: rtl/fid_pkg.sv
package fid_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_ID,
        ST_SKIP
    } fid_state_e;

    localparam int          CMD_BITS   = 8;
    localparam int          ID_LEN     = 4;
    localparam logic [7:0]  OP_READ_ID = 8'h9F;
    localparam logic [7:0]  MFR_CODE   = 8'h1F;
    localparam logic [7:0]  DEV_CODE_0 = 8'h28;
    localparam logic [7:0]  EXT_LEN    = 8'h00;

endpackage

// File: rtl/fid_sync.sv
module fid_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d = q;
        d.chain[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            d.chain[s] = q.chain[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lvl = q.chain[STAGES-1];

endmodule

// File: rtl/fid_ctrl.sv
module fid_ctrl
    import fid_pkg::*;
#(
    parameter int               OP_W    = CMD_BITS,
    parameter logic [OP_W-1:0]  READ_OP = OP_W'(OP_READ_ID)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_hi,
    input  logic            op_done,
    input  logic [OP_W-1:0] op_val,
    output fid_state_e      state
);

    typedef struct packed {
        fid_state_e st;
        logic       cs_prev;
    } ctrl_t;

    ctrl_t q, d;

    always_comb begin
        d = q;
        d.cs_prev = cs_hi;
        if (cs_hi) begin
            d.st = ST_IDLE;
        end else begin
            case (q.st)
                ST_IDLE: if (q.cs_prev) d.st = ST_CMD;
                ST_CMD:  if (op_done) d.st = (op_val == READ_OP) ? ST_ID : ST_SKIP;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, cs_prev: 1'b0};
        else        q <= d;
    end

    assign state = q.st;

    // R10
    start_on_cs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_CMD && $past(q.st) == ST_IDLE) |-> ($past(q.cs_prev) && !$past(cs_hi)));

endmodule

// File: rtl/fid_cmd_rx.sv
module fid_cmd_rx #(
    parameter int CMD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             sck_lvl,
    input  logic             sdi_lvl,
    output logic             done,
    output logic [CMD_W-1:0] op
);

    localparam int CNT_W = $clog2(CMD_W);

    typedef struct packed {
        logic             prev;
        logic [CMD_W-1:0] sr;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic [CMD_W-1:0] op;
    } rx_t;

    rx_t  q, d;
    logic sck_rise;

    assign sck_rise = sck_lvl & ~q.prev;

    always_comb begin
        d = q;
        d.prev = sck_lvl;
        d.done = 1'b0;
        if (!enable) begin
            d.cnt = '0;
        end else if (sck_rise) begin
            d.sr = {q.sr[CMD_W-2:0], sdi_lvl};
            if (q.cnt == CNT_W'(CMD_W - 1)) begin
                d.cnt  = '0;
                d.done = 1'b1;
                d.op   = d.sr;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done = q.done;
    assign op   = q.op;

    // R2
    done_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> ($past(sck_rise) && $past(enable)));

endmodule

// File: rtl/fid_tx.sv
module fid_tx
    import fid_pkg::*;
#(
    parameter logic [7:0] TAIL_ID = 8'h00,
    parameter int         N_BYTES = ID_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic sck_lvl,
    output logic sdo,
    output logic sdo_oe
);

    localparam int IDX_W = $clog2(N_BYTES + 1);

    typedef struct packed {
        logic             prev;
        logic [IDX_W-1:0] idx;
        logic [2:0]       bitp;
        logic             sdo;
        logic             oe;
    } tx_t;

    tx_t  q, d;
    logic sck_fall;

    function automatic logic [7:0] id_byte(input logic [IDX_W-1:0] i);
        if (i == IDX_W'(0))      return MFR_CODE;
        else if (i == IDX_W'(1)) return DEV_CODE_0;
        else if (i == IDX_W'(2)) return TAIL_ID;
        else                     return EXT_LEN;
    endfunction

    assign sck_fall = ~sck_lvl & q.prev;

    always_comb begin
        logic [7:0] cur;
        d = q;
        d.prev = sck_lvl;
        cur = id_byte(q.idx);
        if (!active) begin
            d.idx  = '0;
            d.bitp = '0;
            d.sdo  = 1'b0;
            d.oe   = 1'b0;
        end else if (sck_fall) begin
            d.oe   = 1'b1;
            d.sdo  = cur[3'd7 - q.bitp];
            d.bitp = q.bitp + 1'b1;
            if (q.bitp == 3'd7) begin
                d.idx = (q.idx == IDX_W'(N_BYTES)) ? q.idx : q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sdo    = q.sdo;
    assign sdo_oe = q.oe;

    // R3
    sdo_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.sdo) |-> ($past(sck_fall) || !$past(active)));

    // R5
    tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.idx == IDX_W'(N_BYTES)) |-> (q.sdo == 1'b0));

    // R2
    oe_first_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.oe) |-> ($past(sck_fall) && q.idx == '0 && q.bitp == 3'd1));

endmodule

// File: rtl/spi_id_responder.sv
module spi_id_responder
    import fid_pkg::*;
#(
    parameter logic [7:0] DEV_ID_TAIL = 8'h00,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic sdi,
    output logic sdo,
    output logic sdo_oe
);

    logic [2:0]          pins_s;
    logic                cs_hi;
    logic                sck_s;
    logic                sdi_s;
    logic                op_done;
    logic [CMD_BITS-1:0] op_val;
    fid_state_e          state;

    fid_sync #(
        .W      (3),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({cs_n, sck, sdi}),
        .lvl   (pins_s)
    );

    assign cs_hi = pins_s[2];
    assign sck_s = pins_s[1];
    assign sdi_s = pins_s[0];

    fid_ctrl #(
        .OP_W    (CMD_BITS),
        .READ_OP (OP_READ_ID)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_hi   (cs_hi),
        .op_done (op_done),
        .op_val  (op_val),
        .state   (state)
    );

    fid_cmd_rx #(
        .CMD_W (CMD_BITS)
    ) u_cmd_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (state == ST_CMD),
        .sck_lvl (sck_s),
        .sdi_lvl (sdi_s),
        .done    (op_done),
        .op      (op_val)
    );

    fid_tx #(
        .TAIL_ID (DEV_ID_TAIL),
        .N_BYTES (ID_LEN)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (state == ST_ID),
        .sck_lvl (sck_s),
        .sdo     (sdo),
        .sdo_oe  (sdo_oe)
    );

    // R6
    skip_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> !sdo_oe);

    // R7
    deselect_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_hi, 2) |-> !sdo_oe);

endmodule

// File: tb/test_spi_id_responder.sv
module test_spi_id_responder;

    localparam int         HALF = 8;
    localparam logic [7:0] TAIL = 8'h6C;

    typedef struct packed {
        logic       mode3;
        logic [7:0] op;
        logic [3:0] nbytes;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 8'h9F, 4'd6},
        '{1'b1, 8'h9F, 4'd6},
        '{1'b0, 8'h9E, 4'd2},
        '{1'b1, 8'h1F, 4'd2},
        '{1'b0, 8'hFF, 4'd1},
        '{1'b1, 8'h9F, 4'd4}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic cs_n;
    logic sck;
    logic sdi;
    logic sdo;
    logic sdo_oe;
    int   n_checks = 0;
    int   n_err = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    spi_id_responder #(
        .DEV_ID_TAIL (TAIL)
    ) i_spi_id_responder (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .sck    (sck),
        .sdi    (sdi),
        .sdo    (sdo),
        .sdo_oe (sdo_oe)
    );

    function automatic logic [7:0] exp_byte(input int k);
        case (k)
            0:       return 8'h1F;
            1:       return 8'h28;
            2:       return TAIL;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer_bit(input logic b, output logic got, output logic en, output logic stab);
        sck = 1'b0;
        sdi = b;
        wait_cyc(HALF);
        got = sdo;
        en  = sdo_oe;
        sck = 1'b1;
        wait_cyc(HALF / 2);
        stab = (sdo == got) && (sdo_oe == en);
        wait_cyc(HALF / 2);
    endtask

    task automatic xfer_byte(input logic [7:0] tx, output logic [7:0] rx,
                             output logic en_all, output logic en_any, output logic stab_all);
        logic g, e, s;
        en_all = 1'b1;
        en_any = 1'b0;
        stab_all = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            xfer_bit(tx[i], g, e, s);
            rx[i] = g;
            en_all &= e;
            en_any |= e;
            stab_all &= s;
        end
    endtask

    task automatic frame_begin(input logic mode3);
        sck  = mode3;
        cs_n = 1'b1;
        wait_cyc(2 * HALF);
        cs_n = 1'b0;
        wait_cyc(HALF);
    endtask

    task automatic frame_end(input logic mode3);
        if (!mode3) sck = 1'b0;
        wait_cyc(HALF);
        cs_n = 1'b1;
        wait_cyc(6);
        check(sdo_oe == 1'b0, "R7 oe after chip select release", {7'b0, sdo_oe}, 8'h00);
    endtask

    initial begin
        logic [7:0] rx;
        logic       ea, ey, st;
        rst_n = 1'b0;
        cs_n  = 1'b1;
        sck   = 1'b0;
        sdi   = 1'b0;
        wait_cyc(5);
        check(sdo_oe == 1'b0 && sdo == 1'b0, "R1 outputs during reset", {6'b0, sdo_oe, sdo}, 8'h00);
        rst_n = 1'b1;
        wait_cyc(6);
        check(sdo_oe == 1'b0 && sdo == 1'b0, "R1 outputs after reset", {6'b0, sdo_oe, sdo}, 8'h00);

        // vector walk: R2, R3, R4, R5, R6, R9
        for (int v = 0; v < 6; v++) begin
            frame_begin(VECS[v].mode3);
            xfer_byte(VECS[v].op, rx, ea, ey, st);
            check(sdo_oe == 1'b0, $sformatf("R2 oe before first launch vec %0d", v), {7'b0, sdo_oe}, 8'h00);
            for (int k = 0; k < int'(VECS[v].nbytes); k++) begin
                xfer_byte(8'h00, rx, ea, ey, st);
                if (VECS[v].op == 8'h9F) begin
                    check(rx == exp_byte(k) && ea,
                          $sformatf("%s R9 mode%0d vec %0d byte %0d", (k < 4) ? "R4" : "R5",
                                    VECS[v].mode3 ? 3 : 0, v, k),
                          rx, exp_byte(k));
                    check(st, $sformatf("R3 sdo held while sck high vec %0d byte %0d", v, k),
                          {7'b0, st}, 8'h01);
                end else begin
                    check(!ey, $sformatf("R6 no drive for op %02h byte %0d", VECS[v].op, k),
                          {7'b0, ey}, 8'h00);
                end
            end
            frame_end(VECS[v].mode3);
        end

        // R7: activity while deselected is ignored
        cs_n = 1'b1;
        sck  = 1'b0;
        xfer_byte(8'h9F, rx, ea, ey, st);
        xfer_byte(8'h00, rx, ea, ey, st);
        check(!ey, "R7 no drive while deselected", {7'b0, ey}, 8'h00);
        frame_begin(1'b0);
        xfer_byte(8'h9F, rx, ea, ey, st);
        xfer_byte(8'h00, rx, ea, ey, st);
        check(rx == 8'h1F && ea, "R7 fresh frame after deselected traffic", rx, 8'h1F);
        frame_end(1'b0);

        // R8: abort in the middle of a byte
        frame_begin(1'b1);
        xfer_byte(8'h9F, rx, ea, ey, st);
        xfer_byte(8'h00, rx, ea, ey, st);
        check(rx == 8'h1F, "R8 first byte before abort", rx, 8'h1F);
        for (int i = 0; i < 3; i++) xfer_bit(1'b0, ea, ey, st);
        cs_n = 1'b1;
        wait_cyc(6);
        check(sdo_oe == 1'b0, "R8 oe dropped on mid-byte release", {7'b0, sdo_oe}, 8'h00);
        frame_begin(1'b0);
        xfer_byte(8'h9F, rx, ea, ey, st);
        xfer_byte(8'h00, rx, ea, ey, st);
        check(rx == 8'h1F && ea, "R8 restart byte 0", rx, 8'h1F);
        xfer_byte(8'h00, rx, ea, ey, st);
        check(rx == 8'h28 && ea, "R8 restart byte 1", rx, 8'h28);
        frame_end(1'b0);

        // R10: chip select already low when reset is released
        sck   = 1'b0;
        cs_n  = 1'b0;
        rst_n = 1'b0;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(HALF);
        xfer_byte(8'h9F, rx, ea, ey, st);
        xfer_byte(8'h00, rx, ea, ey, st);
        check(!ey, "R10 no response without chip select fall", {7'b0, ey}, 8'h00);
        frame_end(1'b0);
        frame_begin(1'b0);
        xfer_byte(8'h9F, rx, ea, ey, st);
        xfer_byte(8'h00, rx, ea, ey, st);
        check(rx == 8'h1F && ea, "R10 response after chip select cycled", rx, 8'h1F);
        frame_end(1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog R1..all: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule